// File: doc/BRIEF.md
# Dual-Bank Working Register File

This block stores a processor's working registers. The four main 16-bit register pairs (the accumulator/flag pair and three general pairs) are held twice, once in a primary copy and once in an alternate copy. A single internal bank bit chooses which copy the pair read and write ports reach. The surrounding core issues an exchange command to flip that bit. No data is moved between the copies, so a second exchange brings back the first copy exactly as it was left. This gives a fast way to save and restore the working set, for example around an interrupt handler.

A second, unbanked group holds the registers that have one copy only: two index registers, the stack pointer and one spare special register. The bank bit never affects them. Each exchange keeps the block busy for four clock cycles. During that time, writes and further exchange requests are dropped. A one-cycle done pulse marks the end of the exchange.

Both read ports are registered. Read data appears one cycle after the index is presented. The register contents are read before any write on the same clock edge lands.

Top module: `rf_shadow_bank`

## Requirements
- R1: After synchronous reset, `bank_sel`, `busy` and `xchg_done` are 0, and every pair in both copies and every special register reads as zero.
- R2: A pair write stores `pair_wr_be[1]` into bits 15:8 and `pair_wr_be[0]` into bits 7:0; disabled lanes keep their old value. Read data appears on `pair_rd_data` one clock after `pair_rd_idx` is sampled.
- R3: An exchange request sampled while `busy` is 0 inverts `bank_sel` on that clock edge.
- R4: After an exchange, pair accesses reach the other copy. The copy that was left keeps its contents unchanged, because no data is copied.
- R5: A second exchange restores the original copy exactly, with the same values it held before the first exchange.
- R6: `busy` is high for exactly 4 consecutive cycles after an accepted request. `xchg_done` is high for one cycle, in the cycle right after `busy` falls.
- R7: Pair writes and special-register writes presented while `busy` is high have no effect.
- R8: Exchange requests presented while `busy` is high are ignored: `bank_sel` does not change and the busy period is not extended.
- R9: A pair read or write in the same cycle as an accepted exchange request uses the bank that was active before the toggle.
- R10: Special registers (indices 0 to 3 on the special port) have a single copy. They read the same values and accept writes whatever the value of `bank_sel`, with the same byte-lane rule as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xchg_req | input | 1 | Exchange request; accepted when not busy |
| bank_sel | output | 1 | Active bank (0 = primary copy) |
| busy | output | 1 | High during the 4 exchange cycles |
| xchg_done | output | 1 | One-cycle pulse when an exchange finishes |
| pair_rd_idx | input | 2 | Pair read index |
| pair_rd_data | output | 16 | Registered pair read data |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_idx | input | 2 | Pair write index |
| pair_wr_data | input | 16 | Pair write data |
| pair_wr_be | input | 2 | Pair byte-lane enables (bit 1 = high byte) |
| spec_rd_idx | input | 2 | Special register read index |
| spec_rd_data | output | 16 | Registered special read data |
| spec_wr_en | input | 1 | Special register write enable |
| spec_wr_idx | input | 2 | Special register write index |
| spec_wr_data | input | 16 | Special register write data |
| spec_wr_be | input | 2 | Special byte-lane enables (bit 1 = high byte) |

## Verification
The assertions assume that `xchg_req` is a plain level sampled at each edge. They expect a request held through a busy period to be dropped rather than queued. They also expect reset to be held for at least one edge before the first request. The stimulus drives every input on the falling clock edge and releases the request after one cycle, except in the scenario that deliberately holds it during busy. Expected values come from a bench-side model of both copies and the special group. All results are sampled on falling edges, one cycle after the edge that registers them.

// File: rtl/rf_shadow_pkg.sv
package rf_shadow_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned lanes_for(input int unsigned width);
    return (width + LANE_W - 1) / LANE_W;
  endfunction
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl #(
  parameter int unsigned XCHG_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic xchg_req,
  output logic bank_sel,
  output logic busy,
  output logic xchg_done
);
  localparam int unsigned CW = $clog2(XCHG_CYCLES + 1);

  logic          bank_q;
  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = xchg_req && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        bank_q <= ~bank_q;
        busy_q <= 1'b1;
        cnt_q  <= CW'(XCHG_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign bank_sel  = bank_q;
  assign busy      = busy_q;
  assign xchg_done = done_q;

  // run-length counter for the busy window check
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (busy_q) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bank_q && !busy_q && !done_q));

  // R3
  bank_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (xchg_req && !busy_q) |=> (busy_q && (bank_q != $past(bank_q))));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q || !xchg_req) |=> $stable(bank_q));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_len == (CW+1)'(XCHG_CYCLES)));

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= (CW+1)'(XCHG_CYCLES));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/rf_word_store.sv
module rf_word_store #(
  parameter int unsigned AW     = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [rf_shadow_pkg::lanes_for(DATA_W)-1:0] wbe,
  input  logic [AW-1:0]        raddr,
  output logic [DATA_W-1:0]    rdata
);
  import rf_shadow_pkg::*;
  localparam int unsigned LANES = lanes_for(DATA_W);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] wdata_pad;
  logic [PAD_W-1:0] rdata_pad;
  assign wdata_pad = PAD_W'(wdata);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        rd_q <= '0;
      end else begin
        rd_q <= mem[raddr];
        if (we && wbe[l]) mem[waddr] <= wdata_pad[l*LANE_W +: LANE_W];
      end
    end
    assign rdata_pad[l*LANE_W +: LANE_W] = rd_q;
  end

  assign rdata = rdata_pad[DATA_W-1:0];
endmodule

// File: rtl/rf_shadow_bank.sv
module rf_shadow_bank #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PAIR_IDX_W  = 2,
  parameter int unsigned SPEC_IDX_W  = 2,
  parameter int unsigned XCHG_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xchg_req,
  output logic                  bank_sel,
  output logic                  busy,
  output logic                  xchg_done,
  input  logic [PAIR_IDX_W-1:0] pair_rd_idx,
  output logic [DATA_W-1:0]     pair_rd_data,
  input  logic                  pair_wr_en,
  input  logic [PAIR_IDX_W-1:0] pair_wr_idx,
  input  logic [DATA_W-1:0]     pair_wr_data,
  input  logic [rf_shadow_pkg::lanes_for(DATA_W)-1:0] pair_wr_be,
  input  logic [SPEC_IDX_W-1:0] spec_rd_idx,
  output logic [DATA_W-1:0]     spec_rd_data,
  input  logic                  spec_wr_en,
  input  logic [SPEC_IDX_W-1:0] spec_wr_idx,
  input  logic [DATA_W-1:0]     spec_wr_data,
  input  logic [rf_shadow_pkg::lanes_for(DATA_W)-1:0] spec_wr_be
);
  localparam int unsigned PAIR_AW = PAIR_IDX_W + 1;

  logic bank_q;
  logic busy_q;
  logic pair_we;
  logic spec_we;

  rf_bank_ctrl #(.XCHG_CYCLES(XCHG_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .xchg_req  (xchg_req),
    .bank_sel  (bank_q),
    .busy      (busy_q),
    .xchg_done (xchg_done)
  );

  assign pair_we = pair_wr_en && !busy_q;
  assign spec_we = spec_wr_en && !busy_q;

  // bank bit is the top address bit; both copies share one array
  rf_word_store #(.AW(PAIR_AW), .DATA_W(DATA_W)) u_pairs (
    .clk   (clk),
    .rst   (rst),
    .we    (pair_we),
    .waddr ({bank_q, pair_wr_idx}),
    .wdata (pair_wr_data),
    .wbe   (pair_wr_be),
    .raddr ({bank_q, pair_rd_idx}),
    .rdata (pair_rd_data)
  );

  rf_word_store #(.AW(SPEC_IDX_W), .DATA_W(DATA_W)) u_spec (
    .clk   (clk),
    .rst   (rst),
    .we    (spec_we),
    .waddr (spec_wr_idx),
    .wdata (spec_wr_data),
    .wbe   (spec_wr_be),
    .raddr (spec_rd_idx),
    .rdata (spec_rd_data)
  );

  assign bank_sel = bank_q;
  assign busy     = busy_q;

  // R1
  rd_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (pair_rd_data == '0 && spec_rd_data == '0));

  // R8
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && xchg_req) |=> (bank_q == $past(bank_q)));
endmodule

// File: tb/tb_rf_shadow_bank.sv
module tb_rf_shadow_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xchg_req = 1'b0;
  logic        bank_sel, busy, xchg_done;
  logic [1:0]  pair_rd_idx = '0, pair_wr_idx = '0, pair_wr_be = '0;
  logic [15:0] pair_rd_data, pair_wr_data = '0;
  logic        pair_wr_en = 1'b0;
  logic [1:0]  spec_rd_idx = '0, spec_wr_idx = '0, spec_wr_be = '0;
  logic [15:0] spec_rd_data, spec_wr_data = '0;
  logic        spec_wr_en = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [15:0] mdl_pair [2][4];
  logic [15:0] mdl_spec [4];
  logic        mdl_bank = 1'b0;

  always #10 clk = ~clk;

  rf_shadow_bank dut (
    .clk(clk), .rst(rst), .xchg_req(xchg_req), .bank_sel(bank_sel),
    .busy(busy), .xchg_done(xchg_done),
    .pair_rd_idx(pair_rd_idx), .pair_rd_data(pair_rd_data),
    .pair_wr_en(pair_wr_en), .pair_wr_idx(pair_wr_idx),
    .pair_wr_data(pair_wr_data), .pair_wr_be(pair_wr_be),
    .spec_rd_idx(spec_rd_idx), .spec_rd_data(spec_rd_data),
    .spec_wr_en(spec_wr_en), .spec_wr_idx(spec_wr_idx),
    .spec_wr_data(spec_wr_data), .spec_wr_be(spec_wr_be)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic pair_write(input logic [1:0] idx, input logic [15:0] d, input logic [1:0] be);
    pair_wr_en = 1'b1; pair_wr_idx = idx; pair_wr_data = d; pair_wr_be = be;
    @(negedge clk);
    pair_wr_en = 1'b0;
    mdl_pair[mdl_bank][idx] = merge(mdl_pair[mdl_bank][idx], d, be);
  endtask

  task automatic spec_write(input logic [1:0] idx, input logic [15:0] d, input logic [1:0] be);
    spec_wr_en = 1'b1; spec_wr_idx = idx; spec_wr_data = d; spec_wr_be = be;
    @(negedge clk);
    spec_wr_en = 1'b0;
    mdl_spec[idx] = merge(mdl_spec[idx], d, be);
  endtask

  task automatic pair_check(input string req, input logic [1:0] idx);
    pair_rd_idx = idx;
    @(negedge clk);
    check(req, {16'h0, pair_rd_data}, {16'h0, mdl_pair[mdl_bank][idx]});
  endtask

  task automatic spec_check(input string req, input logic [1:0] idx);
    spec_rd_idx = idx;
    @(negedge clk);
    check(req, {16'h0, spec_rd_data}, {16'h0, mdl_spec[idx]});
  endtask

  // issues one request and walks through the busy window
  task automatic exchange(input string req);
    xchg_req = 1'b1;
    @(negedge clk);
    xchg_req = 1'b0;
    mdl_bank = ~mdl_bank;
    check(req, {31'h0, bank_sel}, {31'h0, mdl_bank});
    for (int i = 0; i < 4; i++) begin
      check("R6 busy", {31'h0, busy}, 32'h1);
      if (i < 3) @(negedge clk);
    end
    @(negedge clk);
    check("R6 busy low", {31'h0, busy}, 32'h0);
    check("R6 done", {31'h0, xchg_done}, 32'h1);
    @(negedge clk);
    check("R6 done pulse", {31'h0, xchg_done}, 32'h0);
  endtask

  task automatic t_reset;
    check("R1 bank", {31'h0, bank_sel}, 32'h0);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 done", {31'h0, xchg_done}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      pair_check("R1 primary", 2'(i));
      spec_check("R1 special", 2'(i));
    end
    exchange("R3 first toggle");
    for (int i = 0; i < 4; i++) pair_check("R1 alternate", 2'(i));
    exchange("R3 toggle back");
  endtask

  task automatic t_lanes;
    pair_write(2'd0, 16'hA1B2, 2'b11);
    pair_check("R2 full", 2'd0);
    pair_write(2'd0, 16'hFFEE, 2'b01);
    pair_check("R2 low lane", 2'd0);
    pair_write(2'd0, 16'h3344, 2'b10);
    pair_check("R2 high lane", 2'd0);
    pair_write(2'd1, 16'h5555, 2'b00);
    pair_check("R2 no lane", 2'd1);
    for (int i = 1; i < 4; i++) pair_write(2'(i), 16'h1000 + 16'(i), 2'b11);
  endtask

  task automatic t_swap;
    logic [15:0] saved [4];
    for (int i = 0; i < 4; i++) saved[i] = mdl_pair[0][i];
    exchange("R3 swap");
    for (int i = 0; i < 4; i++) pair_check("R4 other copy", 2'(i));
    for (int i = 0; i < 4; i++) pair_write(2'(i), 16'hC000 ^ 16'(i * 17), 2'b11);
    for (int i = 0; i < 4; i++) pair_check("R4 alt write", 2'(i));
    exchange("R3 swap back");
    for (int i = 0; i < 4; i++) begin
      pair_rd_idx = 2'(i);
      @(negedge clk);
      check("R5 restore", {16'h0, pair_rd_data}, {16'h0, saved[i]});
    end
    exchange("R3 swap again");
    for (int i = 0; i < 4; i++) pair_check("R4 alt kept", 2'(i));
    exchange("R3 home");
  endtask

  task automatic t_busy_ignore;
    xchg_req = 1'b1;
    @(negedge clk);
    mdl_bank = ~mdl_bank;
    // request held high through busy; writes attempted
    pair_wr_en = 1'b1; pair_wr_idx = 2'd2; pair_wr_data = 16'hDEAD; pair_wr_be = 2'b11;
    spec_wr_en = 1'b1; spec_wr_idx = 2'd1; spec_wr_data = 16'hBEEF; spec_wr_be = 2'b11;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 bank held", {31'h0, bank_sel}, {31'h0, mdl_bank});
      check("R8 busy", {31'h0, busy}, 32'h1);
    end
    xchg_req = 1'b0; pair_wr_en = 1'b0; spec_wr_en = 1'b0;
    @(negedge clk);
    check("R8 no extend", {31'h0, busy}, 32'h0);
    check("R8 bank final", {31'h0, bank_sel}, {31'h0, mdl_bank});
    pair_check("R7 pair ignored", 2'd2);
    spec_check("R7 spec ignored", 2'd1);
    exchange("R3 restore bank");
  endtask

  task automatic t_same_cycle;
    // write and read in request cycle go to the old bank
    pair_rd_idx = 2'd3;
    xchg_req = 1'b1;
    pair_wr_en = 1'b1; pair_wr_idx = 2'd1; pair_wr_data = 16'h7A7A; pair_wr_be = 2'b11;
    @(negedge clk);
    xchg_req = 1'b0; pair_wr_en = 1'b0;
    check("R9 read old bank", {16'h0, pair_rd_data}, {16'h0, mdl_pair[mdl_bank][3]});
    mdl_pair[mdl_bank][1] = 16'h7A7A;
    mdl_bank = ~mdl_bank;
    repeat (5) @(negedge clk);
    pair_check("R9 new bank untouched", 2'd1);
    exchange("R3 back");
    pair_check("R9 old bank written", 2'd1);
  endtask

  task automatic t_special;
    spec_write(2'd0, 16'h1234, 2'b11);
    spec_write(2'd3, 16'hABCD, 2'b01);
    spec_check("R10 lane", 2'd3);
    exchange("R3 spec swap");
    spec_check("R10 shared", 2'd0);
    spec_write(2'd2, 16'h0F0F, 2'b11);
    exchange("R3 spec home");
    spec_check("R10 written in alt", 2'd2);
    spec_check("R10 unchanged", 2'd0);
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 4; i++) mdl_pair[b][i] = '0;
    for (int i = 0; i < 4; i++) mdl_spec[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_swap();
    t_busy_ignore();
    t_same_cycle();
    t_special();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule